// File: doc/BRIEF.md
# Key Matrix Scanner with Two-Frame Confirmation

This block scans a matrix of up to 32 keys built from 8 source lines and 4 return inputs. At each frame tick it sweeps the source lines one at a time, from the first to the eighth. One line is driven on each cycle in which the scan window is open, and the 4 returns are sampled at the end of that step. The pads are shared with display segment drivers, so a source-active flag tells the pad logic when the lines carry key sources rather than segment data. The same flag can also enable the return pull-downs.

When a sweep completes, the new 32-bit image is compared with the image from the previous completed sweep. Only an exact match is copied into the confirmed key latch, so a press or a release shows up after two identical frames at the earliest. A request flag is high whenever the confirmed image holds any pressed key. Software reads the latch only while that flag is high. When the scan-enable control drops, as it does when the display is forced off, scanning stops at once and all key history is cleared.

Top module: `keymat_scanner`

## Requirements
- R1: After reset, all source lines, the source-active flag, the confirmed latch and the request flag are 0.
- R2: During a sweep, exactly one source line is high on each scan step. The first step drives line 0 and the eighth drives line 7. No line is high outside a step.
- R3: The source-active flag is high exactly on the cycles in which a source line is driven.
- R4: Image bit 4*j+k holds return input k sampled while source line j was driven, with 1 meaning pressed. So bits 31:28 belong to line 7 and are read first when the latch is shifted out MSB first.
- R5: The confirmed latch takes the new image only at the end of the eighth step, and only if that image equals the previous complete image. Otherwise the latch holds its value.
- R6: The request flag is high exactly when the confirmed latch is nonzero.
- R7: A frame tick restarts the sweep at line 0. A partially swept image is never compared or kept as the previous image.
- R8: While scan-enable is low, no source line is driven and frame ticks are ignored. One clock after scan-enable goes low, the previous image, the confirmed latch and the request flag are 0.
- R9: A step is taken only on a cycle with the scan window open. Cycles with the window closed inside a sweep drive nothing and do not advance the sweep.
- R10: After the eighth step, open scan-window cycles drive nothing until the next frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse that starts a new sweep |
| scan_win | input | 1 | Scan window open; each open cycle is one step |
| scan_en | input | 1 | Scanning allowed; low clears all key state |
| key_in | input | 4 | Synchronised key return inputs, 1 = pressed |
| src_lines | output | 8 | Key source lines, one-hot during a step |
| src_active | output | 1 | Pads are carrying key sources this cycle |
| key_latch | output | 32 | Confirmed key image |
| key_req | output | 1 | Confirmed image has at least one pressed key |

## Verification
The hardest case to reach is an interrupted sweep. A new frame tick arrives after only a few steps, and the test must show that the partial image neither updates the latch nor becomes the reference for the next comparison. The bench starts a sweep with a pattern that differs from the stored history, cuts it short with a new tick, and then runs two full frames of the same pattern. It expects the latch to stay unchanged after the first full frame and to confirm only after the second. Bouncing patterns that alternate between frames, and a drop of scan-enable between two confirmations, cover the other paths by which history could leak.

// File: rtl/kms_pkg.sv
package kms_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/kms_sequencer.sv
module kms_sequencer
  import kms_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             scan_win,
  input  logic             scan_en,
  output logic [N_SRC-1:0] src_lines,
  output logic             src_active,
  output logic [IDX_W-1:0] step_idx,
  output logic             step_fire,
  output logic             frame_done
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_step;

  assign last_step  = (idx_q == IDX_W'(N_SRC - 1));
  assign step_fire  = scan_en && (state_q == SEQ_RUN) && scan_win && !frame_tick;
  assign frame_done = step_fire && last_step;
  assign src_active = step_fire;
  assign step_idx   = idx_q;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign src_lines[g] = step_fire && (idx_q == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (!scan_en) begin
      state_d = SEQ_IDLE;
      idx_d   = '0;
    end else if (frame_tick) begin
      state_d = SEQ_RUN;
      idx_d   = '0;
    end else if (step_fire) begin
      if (last_step) begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assert_onehot_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_lines));
  assert_active_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_active == (src_lines != '0));
  assert_window_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !scan_win && !frame_tick) |=> $stable(idx_q));
  assert_quiet_after_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (src_lines == '0));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (src_lines == '0));
endmodule

// File: rtl/kms_capture.sv
module kms_capture #(
  parameter int N_SRC = 8,
  parameter int N_RET = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int IMG_W = N_SRC * N_RET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             step_fire,
  input  logic [IDX_W-1:0] step_idx,
  input  logic [N_RET-1:0] key_in,
  output logic [IMG_W-1:0] img_full
);
  logic [IMG_W-1:0] img_q, img_d;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_slot
      logic slot_hit;
      assign slot_hit = step_fire && (step_idx == IDX_W'(g));
      assign img_full[g*N_RET +: N_RET] = slot_hit ? key_in : img_q[g*N_RET +: N_RET];
    end
  endgenerate

  always_comb begin
    img_d = img_q;
    if (!scan_en)       img_d = '0;
    else if (step_fire) img_d = img_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) img_q <= '0;
    else        img_q <= img_d;
  end

  assert_slot_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && step_fire) |=> (img_q[$past(step_idx)*N_RET +: N_RET] == $past(key_in)));
endmodule

// File: rtl/kms_confirm.sv
module kms_confirm #(
  parameter int IMG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             frame_done,
  input  logic [IMG_W-1:0] img_full,
  output logic [IMG_W-1:0] key_latch,
  output logic             key_req
);
  logic [IMG_W-1:0] prev_q, prev_d;
  logic [IMG_W-1:0] latch_q, latch_d;
  logic             req_q, req_d;
  logic             match;

  assign match = (img_full == prev_q);

  always_comb begin
    prev_d  = prev_q;
    latch_d = latch_q;
    req_d   = req_q;
    if (!scan_en) begin
      prev_d  = '0;
      latch_d = '0;
      req_d   = 1'b0;
    end else if (frame_done) begin
      prev_d = img_full;
      if (match) begin
        latch_d = img_full;
        req_d   = |img_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
      req_q   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      latch_q <= latch_d;
      req_q   <= req_d;
    end
  end

  assign key_latch = latch_q;
  assign key_req   = req_q;

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !frame_done) |=> $stable(latch_q));
  assert_mismatch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && frame_done && !match) |=> $stable(latch_q));
  assert_req_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q == (latch_q != '0));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (latch_q == '0 && prev_q == '0 && !req_q));
endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner #(
  parameter int N_SRC = 8,
  parameter int N_RET = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int IMG_W = N_SRC * N_RET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             scan_win,
  input  logic             scan_en,
  input  logic [N_RET-1:0] key_in,
  output logic [N_SRC-1:0] src_lines,
  output logic             src_active,
  output logic [IMG_W-1:0] key_latch,
  output logic             key_req
);
  logic [IDX_W-1:0] step_idx;
  logic             step_fire;
  logic             frame_done;
  logic [IMG_W-1:0] img_full;

  kms_sequencer #(.N_SRC(N_SRC)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .scan_win(scan_win),
    .scan_en(scan_en), .src_lines(src_lines), .src_active(src_active),
    .step_idx(step_idx), .step_fire(step_fire), .frame_done(frame_done)
  );

  kms_capture #(.N_SRC(N_SRC), .N_RET(N_RET)) u_cap (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .step_fire(step_fire),
    .step_idx(step_idx), .key_in(key_in), .img_full(img_full)
  );

  kms_confirm #(.IMG_W(IMG_W)) u_conf (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .frame_done(frame_done),
    .img_full(img_full), .key_latch(key_latch), .key_req(key_req)
  );
endmodule

// File: tb/keymat_scanner_bench.sv
module keymat_scanner_bench;
  localparam time CLK_P = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        scan_win = 1'b0;
  logic        scan_en = 1'b1;
  logic [3:0]  key_in;
  logic [7:0]  src_lines;
  logic        src_active;
  logic [31:0] key_latch;
  logic        key_req;
  logic [31:0] pressed = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] lat;
    logic        req;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  event sb_evt;
  logic [31:0] m_prev = '0;
  logic [31:0] m_latch = '0;

  always #(CLK_P/2) clk = ~clk;

  keymat_scanner u_keymat_scanner (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .scan_win(scan_win),
    .scan_en(scan_en), .key_in(key_in), .src_lines(src_lines),
    .src_active(src_active), .key_latch(key_latch), .key_req(key_req)
  );

  // Key matrix: return k is high when a driven source line has key (j,k) closed.
  always_comb begin
    key_in = '0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 4; k++)
        if (src_lines[j] && pressed[4*j+k]) key_in[k] = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops expected confirmed state after each completed sweep.
  initial begin
    forever begin
      @(sb_evt);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(key_latch === e.lat, {"R5 latch ", e.tag}, key_latch, e.lat);
        chk(key_req === e.req, {"R6 request ", e.tag}, {31'b0, key_req}, {31'b0, e.req});
      end
    end
  end

  task automatic pulse_tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  // Driver: one full sweep with an optional closed-window cycle after each step.
  task automatic do_frame(input logic [31:0] p, input string tag, input bit gaps);
    pressed = p;
    pulse_tick();
    for (int j = 0; j < 8; j++) begin
      scan_win = 1'b1;
      #1;
      chk(src_lines === 8'(1 << j), "R2 source order", {24'b0, src_lines}, 32'(1 << j));
      chk(src_active === 1'b1, "R3 active on step", {31'b0, src_active}, 32'd1);
      @(negedge clk);
      if (gaps) begin
        scan_win = 1'b0;
        #1;
        chk(src_lines === 8'h00 && !src_active, "R9 closed window", {24'b0, src_lines}, 32'd0);
        @(negedge clk);
      end
    end
    scan_win = 1'b0;
    if (p == m_prev) m_latch = p;
    m_prev = p;
    exp_q.push_back('{m_latch, (m_latch != 0), tag});
    ->sb_evt;
    #0;
  endtask

  task automatic partial(input logic [31:0] p, input int n);
    pressed = p;
    pulse_tick();
    for (int j = 0; j < n; j++) begin
      scan_win = 1'b1;
      @(negedge clk);
    end
    scan_win = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(src_lines === 8'h00, "R1 reset sources", {24'b0, src_lines}, 32'd0);
    chk(src_active === 1'b0, "R1 reset active", {31'b0, src_active}, 32'd0);
    chk(key_latch === 32'h0, "R1 reset latch", key_latch, 32'h0);
    chk(key_req === 1'b0, "R1 reset request", {31'b0, key_req}, 32'd0);

    // Window open before any frame tick: nothing driven (R10).
    scan_win = 1'b1; #1;
    chk(src_lines === 8'h00, "R10 no sweep without tick", {24'b0, src_lines}, 32'd0);
    @(negedge clk) scan_win = 1'b0;

    // R4 mapping: line 1 return 0, then line 7 return 3 plus line 0 return 0.
    do_frame(32'h0000_0010, "first press frame 1", 1'b0);
    do_frame(32'h0000_0010, "first press frame 2", 1'b0);
    do_frame(32'h8000_0001, "R4 corners frame 1", 1'b1);
    do_frame(32'h8000_0001, "R4 corners frame 2", 1'b0);

    // After a sweep, extra window cycles drive nothing (R10).
    @(negedge clk) scan_win = 1'b1; #1;
    chk(src_lines === 8'h00, "R10 idle after sweep", {24'b0, src_lines}, 32'd0);
    @(negedge clk) scan_win = 1'b0;

    // Bounce: alternating images never confirm.
    do_frame(32'h0F00_00F0, "bounce a", 1'b0);
    do_frame(32'h0E00_00F0, "bounce b", 1'b0);
    do_frame(32'h0F00_00F0, "bounce c", 1'b0);

    // Release everything: needs two frames.
    do_frame(32'h0, "release 1", 1'b0);
    do_frame(32'h0, "release 2", 1'b0);

    // Confirm a pattern, then drop scan-enable (R8).
    do_frame(32'h1234_5678, "pre-disable 1", 1'b0);
    do_frame(32'h1234_5678, "pre-disable 2", 1'b0);
    @(negedge clk);
    scan_en = 1'b0;
    frame_tick = 1'b1;
    scan_win = 1'b1;
    #1;
    chk(src_lines === 8'h00, "R8 no drive while disabled", {24'b0, src_lines}, 32'd0);
    @(negedge clk);
    frame_tick = 1'b0;
    chk(key_latch === 32'h0, "R8 latch cleared", key_latch, 32'h0);
    chk(key_req === 1'b0, "R8 request cleared", {31'b0, key_req}, 32'd0);
    @(negedge clk);
    chk(src_lines === 8'h00, "R8 tick ignored while disabled", {24'b0, src_lines}, 32'd0);
    scan_win = 1'b0;
    scan_en = 1'b1;
    m_prev = '0;
    m_latch = '0;
    // History cleared: the same pattern must again take two frames.
    do_frame(32'h1234_5678, "R8 history cleared 1", 1'b0);
    do_frame(32'h1234_5678, "R8 history cleared 2", 1'b0);

    // R7: interrupted sweep with a new pattern, then two full frames.
    partial(32'hC000_0003, 3);
    do_frame(32'hC000_0003, "R7 after abort 1", 1'b0);
    do_frame(32'hC000_0003, "R7 after abort 2", 1'b0);

    // Wait, then finish.
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule